// File: doc/BRIEF.md
# Configuration Stream Unpacker

This block walks a compressed configuration image held in a word-addressed source memory and turns it into a sequence of register writes. After a start pulse it fetches 32-bit words one at a time, beginning at a given memory address. Each record is decoded and expanded into one or more (address, data) writes. Decoding stops at the first terminating header. It then raises a one-cycle done pulse and reports how many words it consumed.

There are two record kinds. A single-register record names one register and carries its value, and may borrow a second word for the upper bits. A block record names a start address, a register count, a field width and an address stride. The data words that follow it hold several narrow fields each. Because the end condition is any header with a zero count, an unsupported width or a stride of 0 or 3, many different words can act as the end marker.

The memory side is a request/response pair, both valid/ready. A request stays valid, with a stable address, until it is accepted. Only one request is ever outstanding. The block holds response-ready high only while it waits for that request's reply, so the memory may delay the reply for any number of cycles. The register side has no ready signal: each write is a one-cycle strobe. While the stall input is high no strobe is issued, and decoding waits with the pending address and data held.

Top module: `cfg_unpacker`

## Requirements
- R1: A start pulse accepted in idle makes the block read memory at start_addr, then at start_addr+1, +2 and so on, one word per accepted request. mem_req_valid stays high with mem_req_addr unchanged until mem_req_ready accepts it.
- R2: A header with bit 0 = 1 and bit 1 = 0 produces one write. The address is header bits 31..18, zero-extended. The data is header bits 17..2, zero-extended.
- R3: A header with bit 0 = 1 and bit 1 = 1 consumes the following word W as well. It writes (W with bit 0 cleared) OR (header bits 17..2), to the address given by header bits 31..18.
- R4: A header with bit 0 = 0 is a block. Start address is bits 31..16, register count bits 15..8, field width minus one bits 7..3, and address step bits 2..1.
- R5: Each block data word has its fields packed from bit 1 upward, lowest field first. Each field is written zero-extended to 32 bits. A new data word is fetched when the unused bits of the current word are fewer than the width. With width 31 every data word carries exactly one register.
- R6: Each write in a block goes to the previous write address plus the step, modulo 2^REG_AW.
- R7: The word after a block's last data word is read as the next header. Unused bits left in that last data word are discarded.
- R8: A block header with count 0, with a width other than 5, 6, 7, 10, 15 or 31, or with step 0 or 3, ends decoding. No further writes and no further reads follow it.
- R9: done is high for exactly one cycle when decoding ends. At that point words_used equals the number of words read since the start, counting the terminating header. words_used then holds until the next start. After reset, busy, done, wr_en and words_used are 0.
- R10: While wr_stall is high, wr_en stays low and decoding holds. The held write is issued with the same address and data in the first cycle wr_stall is low.
- R11: A start pulse while busy is high is ignored.
- R12: At most one memory request is outstanding. mem_rsp_ready is high only after an accepted request and until its response. mem_req_valid is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding (honoured only when idle) |
| start_addr | input | MEM_AW | Memory address of the first header |
| busy | output | 1 | Decoding in progress |
| done | output | 1 | One-cycle pulse at end of stream |
| words_used | output | CNT_W | Words read since the last start |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | MEM_AW | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Block waits for read data |
| mem_rsp_data | input | 32 | Read data word |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | REG_AW | Register write address |
| wr_data | output | 32 | Register write data |
| wr_stall | input | 1 | Hold decoding and suppress writes |

## Verification
The bench uses the default parameters: a 16-bit memory address, a 16-bit register address and a 16-bit word counter. The 16-bit register address lets a block starting at 0xFFFE with step 2 wrap through zero, and the streams stay far below the counter limit. Random streams mix single and wide-single records with blocks of every legal width, count and step. Directed streams end on each kind of terminator and are followed by garbage, so a missed end shows up as extra writes or reads. Random memory latency, request back-pressure and write stalls cover the hold paths. One run also fires a start while the block is busy.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
  localparam int WORD_W  = 32;
  localparam int FW_W    = 5;
  localparam int AVAIL_W = 6;
  localparam int CNTF_W  = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_HI, ST_SWR, ST_DAT, ST_FWR, ST_DONE
  } state_t;

  typedef struct packed {
    logic              is_single;
    logic              wide;
    logic [13:0]       s_addr;
    logic [15:0]       s_lo;
    logic [15:0]       b_addr;
    logic [CNTF_W-1:0] b_count;
    logic [FW_W-1:0]   b_width;
    logic [1:0]        b_step;
    logic              b_end;
  } hdr_t;

  function automatic logic width_ok(input logic [FW_W-1:0] wm1);
    case (wm1)
      5'd4, 5'd5, 5'd6, 5'd9, 5'd14, 5'd30: width_ok = 1'b1;
      default:                              width_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cfgu_hdr_dec.sv
module cfgu_hdr_dec
  import cfgu_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output hdr_t              hdr
);
  logic [FW_W-1:0] wm1;
  assign wm1 = word[7:3];

  always_comb begin
    hdr.is_single = word[0];
    hdr.wide      = word[1];
    hdr.s_addr    = word[31:18];
    hdr.s_lo      = word[17:2];
    hdr.b_addr    = word[31:16];
    hdr.b_count   = word[15:8];
    hdr.b_width   = wm1 + 5'd1;
    hdr.b_step    = word[2:1];
    hdr.b_end     = (word[15:8] == '0) || !width_ok(wm1) ||
                    (word[2:1] == 2'd0) || (word[2:1] == 2'd3);
  end
endmodule

// File: rtl/cfgu_fetch.sv
module cfgu_fetch #(
  parameter int MEM_AW = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] start_addr,
  input  logic              want,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [MEM_AW-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_data,
  output logic              word_vld,
  output logic [31:0]       word,
  output logic [CNT_W-1:0]  words_used
);
  logic              waiting;
  logic [MEM_AW-1:0] ptr;

  assign req_valid = want && !waiting;
  assign rsp_ready = waiting;
  assign word_vld  = waiting && rsp_valid;
  assign word      = rsp_data;
  assign req_addr  = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting    <= 1'b0;
      ptr        <= '0;
      words_used <= '0;
    end else if (start) begin
      ptr        <= start_addr;
      words_used <= '0;
    end else begin
      if (req_valid && req_ready) begin
        waiting <= 1'b1;
        ptr     <= ptr + 1'b1;
      end
      if (word_vld) begin
        waiting    <= 1'b0;
        words_used <= words_used + 1'b1;
      end
    end
  end

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  assert_rsp_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(req_valid && req_ready));
endmodule

// File: rtl/cfgu_field_ext.sv
module cfgu_field_ext
  import cfgu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              take,
  input  logic [FW_W-1:0]   width,
  output logic [WORD_W-1:0] field,
  output logic              fits_next
);
  logic [WORD_W-2:0]  sh;
  logic [AVAIL_W-1:0] avail;
  logic [WORD_W-1:0]  mask;

  assign mask      = (32'd1 << width) - 32'd1;
  assign field     = {1'b0, sh} & mask;
  assign fits_next = {1'b0, avail} >= {1'b0, width, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      avail <= '0;
    end else if (load) begin
      sh    <= load_word[WORD_W-1:1];
      avail <= AVAIL_W'(WORD_W - 1);
    end else if (take) begin
      sh    <= sh >> width;
      avail <= avail - {1'b0, width};
    end
  end

  assert_take_in_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> avail >= {1'b0, width});
endmodule

// File: rtl/cfg_unpacker.sv
module cfg_unpacker
  import cfgu_pkg::*;
#(
  parameter int MEM_AW = 16,
  parameter int REG_AW = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MEM_AW-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  words_used,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              wr_en,
  output logic [REG_AW-1:0] wr_addr,
  output logic [31:0]       wr_data,
  input  logic              wr_stall
);
  state_t             st;
  logic [REG_AW-1:0]  cur_addr;
  logic [CNTF_W-1:0]  rem;
  logic [FW_W-1:0]    fw;
  logic [1:0]         fstep;
  logic [WORD_W-1:0]  sval;
  logic               go, want, word_vld, take, fits_next;
  logic [WORD_W-1:0]  word, field;
  hdr_t               hdr;

  assign go   = start && (st == ST_IDLE);
  assign want = (st == ST_HDR) || (st == ST_HI) || (st == ST_DAT);
  assign take = (st == ST_FWR) && !wr_stall;

  cfgu_fetch #(.MEM_AW(MEM_AW), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(go), .start_addr(start_addr), .want(want),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ready(mem_rsp_ready), .rsp_data(mem_rsp_data),
    .word_vld(word_vld), .word(word), .words_used(words_used)
  );

  cfgu_hdr_dec u_dec (.word(word), .hdr(hdr));

  cfgu_field_ext u_ext (
    .clk(clk), .rst_n(rst_n), .load((st == ST_DAT) && word_vld), .load_word(word),
    .take(take), .width(fw), .field(field), .fits_next(fits_next)
  );

  assign busy    = (st != ST_IDLE);
  assign done    = (st == ST_DONE);
  assign wr_en   = ((st == ST_SWR) || (st == ST_FWR)) && !wr_stall;
  assign wr_addr = cur_addr;
  assign wr_data = (st == ST_FWR) ? field : sval;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      fw       <= '0;
      fstep    <= '0;
      sval     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) st <= ST_HDR;
        ST_HDR: if (word_vld) begin
          if (hdr.is_single) begin
            cur_addr <= REG_AW'(hdr.s_addr);
            sval     <= {16'd0, hdr.s_lo};
            st       <= hdr.wide ? ST_HI : ST_SWR;
          end else if (hdr.b_end) begin
            st <= ST_DONE;
          end else begin
            cur_addr <= REG_AW'(hdr.b_addr);
            rem      <= hdr.b_count;
            fw       <= hdr.b_width;
            fstep    <= hdr.b_step;
            st       <= ST_DAT;
          end
        end
        ST_HI: if (word_vld) begin
          sval <= {word[WORD_W-1:1], 1'b0} | {16'd0, sval[15:0]};
          st   <= ST_SWR;
        end
        ST_SWR: if (!wr_stall) st <= ST_HDR;
        ST_DAT: if (word_vld) st <= ST_FWR;
        ST_FWR: if (!wr_stall) begin
          cur_addr <= cur_addr + REG_AW'(fstep);
          rem      <= rem - 1'b1;
          if (rem == 8'd1)     st <= ST_HDR;
          else if (!fits_next) st <= ST_DAT;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_FWR) || (st == ST_SWR)) && wr_stall |=>
      (st == $past(st)) && $stable(wr_addr) && $stable(wr_data));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !done |=> busy);
endmodule

// File: tb/test_cfg_unpacker.sv
module test_cfg_unpacker;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] start_addr = 0;
  logic        busy, done, mem_req_valid, mem_rsp_ready, wr_en;
  logic [15:0] words_used, mem_req_addr, wr_addr;
  logic        mem_req_ready = 0, mem_rsp_valid = 0, wr_stall = 0;
  logic [31:0] mem_rsp_data = 0, wr_data;

  always #10 clk = ~clk;

  cfg_unpacker i_cfg_unpacker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .done(done), .words_used(words_used), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_stall(wr_stall)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:4095];
  logic [15:0] exp_a [0:511];
  logic [31:0] exp_d [0:511];
  string       exp_t [0:511];
  int exp_n, exp_words, wr_idx, gp, done_cnt;
  logic [15:0] exp_ptr, done_words;
  bit pending = 0, stall_en = 0;
  int lat = 0;
  logic [15:0] paddr = 0;
  string blk_tag = "R5 R6";

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  function automatic bit legal_w(input int w);
    return w == 5 || w == 6 || w == 7 || w == 10 || w == 15 || w == 31;
  endfunction

  // Reference decoder: computes expected writes and word count from mem.
  task automatic model(input int base);
    int p = base;
    exp_n = 0;
    forever begin
      logic [31:0] h = mem[p];
      p++;
      if (h[0]) begin
        logic [31:0] v = {16'd0, h[17:2]};
        string t = "R2";
        if (h[1]) begin
          v = (mem[p] & 32'hFFFF_FFFE) | v;
          p++;
          t = "R3";
        end
        exp_a[exp_n] = {2'b0, h[31:18]}; exp_d[exp_n] = v; exp_t[exp_n] = t; exp_n++;
      end else begin
        int cnt = h[15:8], w = int'(h[7:3]) + 1, s = h[2:1], per;
        if (cnt == 0 || !legal_w(w) || s == 0 || s == 3) break;
        per = 31 / w;
        for (int i = 0; i < cnt; i++) begin
          logic [63:0] wd = {32'd0, mem[p + i / per]};
          exp_a[exp_n] = 16'(int'(h[31:16]) + i * s);
          exp_d[exp_n] = 32'((wd >> (1 + (i % per) * w)) & ((64'd1 << w) - 1));
          exp_t[exp_n] = (i == 0) ? "R4" : blk_tag;
          exp_n++;
        end
        p += (cnt + per - 1) / per;
      end
    end
    exp_words = p - base;
  endtask

  task automatic put(input logic [31:0] w);
    mem[gp] = w; gp++;
  endtask

  task automatic add_single(input logic [13:0] a, input logic [31:0] v, input bit wide);
    put({a, v[15:0], wide, 1'b1});
    if (wide) put($urandom | 32'd1);
  endtask

  task automatic add_block(input logic [15:0] a, input int cnt, input int w, input int s);
    int per = 31 / w;
    put({a, 8'(cnt), 5'(w - 1), 2'(s), 1'b0});
    for (int i = 0; i < (cnt + per - 1) / per; i++) put($urandom | 32'd1);
  endtask

  task automatic rand_stream(input int base);
    int ws [6] = '{5, 6, 7, 10, 15, 31};
    gp = base;
    for (int r = 0; r < 1 + $urandom % 6; r++) begin
      if ($urandom % 2) add_single(14'($urandom), $urandom, 1'($urandom));
      else add_block(16'($urandom), 1 + $urandom % 20, ws[$urandom % 6], 1 + $urandom % 2);
    end
    case ($urandom % 3)
      0: put(32'd0);
      1: put(32'h7FFF_00FE);
      default: put({16'h0040, 8'd3, 5'd7, 2'd1, 1'b0});
    endcase
    put(32'h0000_0001); put(32'hFFFF_FFFF);
  endtask

  task automatic do_run(input int base, input bit busy_start);
    int prev, t;
    model(base);
    wr_idx = 0; prev = done_cnt;
    @(negedge clk); start = 1; start_addr = 16'(base); exp_ptr = 16'(base);
    @(negedge clk); start = 0;
    if (busy_start) begin
      repeat (8) @(negedge clk);
      chk(busy == 1'b1, "R11", $sformatf("busy act=%0b exp=1", busy));
      start = 1; start_addr = 16'(base + 100);
      @(negedge clk); start = 0;
    end
    t = 0;
    while (done_cnt == prev && t < 30000) begin @(negedge clk); t++; end
    chk(done_cnt != prev, "R9", "done never seen act=0 exp=1");
    chk(done_words == 16'(exp_words), "R9",
        $sformatf("words_used act=%0d exp=%0d", done_words, exp_words));
    chk(wr_idx == exp_n, "R7", $sformatf("write count act=%0d exp=%0d", wr_idx, exp_n));
    @(negedge clk); #2;
    chk(!done && !busy, "R9", $sformatf("done after pulse act=%0b exp=0", done));
    chk(words_used == 16'(exp_words), "R9",
        $sformatf("words held act=%0d exp=%0d", words_used, exp_words));
    repeat (5) @(negedge clk);
    #2 chk(!mem_req_valid, "R8", $sformatf("read after end act=%0b exp=0", mem_req_valid));
  endtask

  // Memory model, stall driver and monitors.
  always @(negedge clk) begin
    if (pending && lat > 0) lat--;
    mem_rsp_valid <= pending && lat == 0;
    mem_rsp_data  <= pending ? mem[paddr[11:0]] : $urandom;
    mem_req_ready <= !pending && ($urandom % 4 != 0);
    wr_stall      <= stall_en && ($urandom % 3 == 0);
    #1;
    if (rst_n) begin
      if (mem_req_valid && mem_rsp_ready)
        chk(0, "R12", "req_valid while response pending act=1 exp=0");
      if (mem_rsp_valid && mem_rsp_ready) pending = 0;
      if (mem_req_valid && mem_req_ready) begin
        chk(mem_req_addr == exp_ptr, "R1",
            $sformatf("read addr act=%h exp=%h", mem_req_addr, exp_ptr));
        exp_ptr++;
        pending = 1; paddr = mem_req_addr; lat = $urandom % 3;
      end
      if (wr_stall) chk(!wr_en, "R10", $sformatf("wr_en in stall act=%0b exp=0", wr_en));
      if (wr_en) begin
        if (wr_idx >= exp_n) chk(0, "R8", $sformatf("extra write addr=%h act=1 exp=0", wr_addr));
        else chk(wr_addr == exp_a[wr_idx] && wr_data == exp_d[wr_idx], exp_t[wr_idx],
                 $sformatf("write %0d act=%h:%h exp=%h:%h", wr_idx, wr_addr, wr_data,
                           exp_a[wr_idx], exp_d[wr_idx]));
        wr_idx++;
      end
      if (done) begin done_cnt++; done_words = words_used; end
    end
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    chk(0, "R9", "watchdog expired act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    done_cnt = 0; exp_n = 0; wr_idx = 0; exp_ptr = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    #2;
    chk(!busy && !done && !wr_en && !mem_req_valid && words_used == 0, "R9",
        $sformatf("reset outputs act=%b%b%b%b/%0d exp=0000/0", busy, done, wr_en,
                  mem_req_valid, words_used));
    rst_n = 1;
    // Directed: every record form and every legal width
    gp = 0;
    add_single(14'h1234, 32'h0000_BEEF, 0);
    add_single(14'h3FFF, 32'hA5A5_1234, 1);
    add_block(16'h0100, 3, 15, 1);
    add_block(16'h0200, 2, 31, 2);
    add_block(16'h0300, 7, 5, 1);
    add_block(16'h0400, 5, 7, 2);
    add_block(16'h0500, 6, 6, 1);
    add_block(16'h0600, 4, 10, 1);
    put(32'd0);
    put(32'h0000_0001);
    do_run(0, 1);
    // Address wrap, end on 0x7FFF00FE marker
    gp = 300; blk_tag = "R6";
    add_block(16'hFFFE, 3, 10, 2);
    put(32'h7FFF_00FE); put(32'h0000_0005);
    do_run(300, 0);
    blk_tag = "R5 R6";
    // Illegal width (8) ends decoding
    gp = 400;
    add_single(14'h0011, 32'h0000_0022, 0);
    put({16'h0700, 8'd4, 5'd7, 2'd1, 1'b0}); put(32'hFFFF_FFFF); put(32'h0000_0001);
    do_run(400, 0);
    // Step 0 and step 3 end decoding
    gp = 500;
    put({16'h0800, 8'd2, 5'd4, 2'd0, 1'b0}); put(32'hFFFF_FFFF);
    do_run(500, 0);
    gp = 600;
    add_block(16'h0900, 1, 31, 1);
    put({16'h0A00, 8'd2, 5'd14, 2'd3, 1'b0}); put(32'hFFFF_FFFF);
    do_run(600, 0);
    // Random streams, with and without stalls
    for (int k = 0; k < 10; k++) begin
      stall_en = k[0];
      rand_stream(1024 + k * 256);
      do_run(1024 + k * 256, 0);
    end
    stall_en = 1;
    gp = 0;
    do_run(0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule